// File: doc/BRIEF.md
# Register Access Channel Controller

This block is one host-side channel that turns single 32-bit command words into register transactions on a serial link toward a power-management device. The host issues a command word that selects a read or a write, names a 16-bit device register and, for writes, carries the data. A state machine then runs the transaction through a small request/acknowledge stub that stands in for the serial shifter. After the acknowledge, it waits for the data line to return to idle.

A finished read is not dropped. The channel parks in a dedicated waiting state and keeps the returned data visible in its status word. It stays there until the host issues a valid-clear strobe with its data bit set. A finished write goes straight back to idle. Software polls one 32-bit status word. That word carries the last read data, the state code, a request-pending flag, a mirror of the link idle line, a host-set initialised flag, a sticky rejection flag and the enable bit.

The channel accepts nothing until the host enables it. Any command that arrives while it is disabled or busy is dropped, and the sticky rejection flag records the drop.

Top module: `rac_channel`

## Requirements
- R1: A command word is decoded as bit 31 = write (1) or read (0), bits 30:16 = device byte address divided by two, and bits 15:0 = write data. While a transaction is requested, linkWrite, linkAddr and linkWdata present these three fields.
- R2: The state code is 0 when idle, 2 while requesting, 4 while waiting for the data line to go idle, and 6 while holding read data for valid-clear. No other code ever appears.
- R3: statusWord bit layout is as follows. Bits 15:0 hold the last read data. Bits 18:16 hold the state code. Bit 19 is 1 while a request is pending. Bit 20 is linkIdle as registered on the previous clock edge. Bit 21 is the initialised flag. Bit 22 is the sticky rejection flag. Bit 23 is the enable bit. Bits 31:24 are 0.
- R4: A read captures linkRdata on the acknowledge. Once linkIdle is seen, the read enters state 6 and stays there with its data unchanged. Only a vldClrWr pulse with vldClrBit = 1 returns it to idle. A pulse with vldClrBit = 0 has no effect.
- R5: A write returns from state 4 directly to idle once linkIdle is seen. It never enters state 6 and leaves the read-data field unchanged.
- R6: A command issued while the state code is not 0 is ignored and sets the sticky rejection flag. The flag is cleared by a cfgWr with cfgData bit 2 = 1. A rejection in the same cycle takes priority over the clear.
- R7: While the enable bit is 0, a command is ignored and the channel stays idle, and the rejection flag is set. A cfgWr loads the enable bit from cfgData bit 0 and the initialised flag from cfgData bit 1.
- R8: Under reset, statusWord is all zero and linkReq is low.
- R9: linkReq stays high, with linkAddr unchanged, from the cycle after a command is accepted until the cycle in which linkAck is sampled high.
- R10: A valid-clear pulse while the state code is not 6 has no effect on the state or on the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdWr | input | 1 | Command word write strobe |
| cmdWord | input | 32 | Command word (R1 layout) |
| vldClrWr | input | 1 | Valid-clear write strobe |
| vldClrBit | input | 1 | Valid-clear data bit; 1 releases a parked read |
| cfgWr | input | 1 | Configuration write strobe |
| cfgData | input | 3 | bit0 enable, bit1 initialised, bit2 clear rejection flag |
| statusWord | output | 32 | Status word (R3 layout) |
| linkReq | output | 1 | Transaction request to the serial stub |
| linkWrite | output | 1 | 1 for write, 0 for read |
| linkAddr | output | 15 | Device register address divided by two |
| linkWdata | output | 16 | Write data |
| linkAck | input | 1 | Stub acknowledge, one cycle |
| linkRdata | input | 16 | Read data, valid with linkAck |
| linkIdle | input | 1 | Data line idle indication |

## Verification
Several properties are checked on every cycle:
- an accepted command always enters the request state;
- a parked read holds both its state and its data until a clear with the bit set, and then goes idle;
- a command issued while busy always raises the rejection flag;
- the request and its address hold until acknowledged;
- the state code stays even.

Other behaviour depends on full transactions and is shown only by the bench's scenarios. This covers the command field decode against the address-halving rule, and the write path's bypass of the parked state. It also covers the one-cycle lag of the idle mirror, the effect of a zero-valued clear, stray clears while idle, and the disabled-channel case. These scenarios run under varied acknowledge and line-idle delays.

// File: rtl/rac_pkg.sv
package rac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd2,
    ST_WAIT_LINE = 3'd4,
    ST_WAIT_CLR  = 3'd6
  } racState_e;

  typedef struct packed {
    logic accept;
    logic reject;
    logic capture;
    logic reqPend;
  } racStrobe_t;

  localparam int STATE_W = 3;
  localparam int CFG_EN_BIT = 0;
  localparam int CFG_INIT_BIT = 1;
  localparam int CFG_CLR_BIT = 2;
  localparam int CFG_W = 3;

endpackage

// File: rtl/rac_ctrl.sv
module rac_ctrl
  import rac_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdWr,
  input  logic               vldClrWr,
  input  logic               vldClrBit,
  input  logic               chanEn,
  input  logic               cmdIsWrite,
  input  logic               linkAck,
  input  logic               linkIdle,
  output racStrobe_t         strobe,
  output logic [STATE_W-1:0] fsmCode,
  output logic               linkReq
);

  racState_e stateQ, stateNxt;
  logic      acceptNow;
  logic      isIdle;

  assign isIdle    = (stateQ == ST_IDLE);
  assign acceptNow = cmdWr && chanEn && isIdle;

  always_comb begin
    stateNxt = stateQ;
    unique case (stateQ)
      ST_IDLE:      if (acceptNow) stateNxt = ST_REQ;
      ST_REQ:       if (linkAck) stateNxt = ST_WAIT_LINE;
      ST_WAIT_LINE: if (linkIdle) stateNxt = cmdIsWrite ? ST_IDLE : ST_WAIT_CLR;
      ST_WAIT_CLR:  if (vldClrWr && vldClrBit) stateNxt = ST_IDLE;
      default:      stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNxt;
  end

  always_comb begin
    strobe.accept  = acceptNow;
    strobe.reject  = cmdWr && !acceptNow;
    strobe.capture = (stateQ == ST_REQ) && linkAck && !cmdIsWrite;
    strobe.reqPend = (stateQ == ST_REQ);
  end

  assign fsmCode = stateQ;
  assign linkReq = (stateQ == ST_REQ);

endmodule

// File: rtl/rac_dpath.sv
module rac_dpath
  import rac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int CMD_W  = 1 + ADDR_W + DATA_W,
  localparam int STAT_W = DATA_W + 16
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [CMD_W-1:0]   cmdWord,
  input  logic               cfgWr,
  input  logic [CFG_W-1:0]   cfgData,
  input  racStrobe_t         strobe,
  input  logic [STATE_W-1:0] fsmCode,
  input  logic [DATA_W-1:0]  linkRdata,
  input  logic               linkIdle,
  output logic               chanEn,
  output logic               cmdIsWrite,
  output logic [ADDR_W-1:0]  linkAddr,
  output logic [DATA_W-1:0]  linkWdata,
  output logic [STAT_W-1:0]  statusWord
);

  localparam int WR_BIT   = ADDR_W + DATA_W;
  localparam int FLAG_W   = 5;
  localparam int PAD_W    = STAT_W - DATA_W - STATE_W - FLAG_W;

  logic              writeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              enQ;
  logic              initQ;
  logic              errQ;
  logic              syncIdleQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      writeQ <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.accept) begin
      writeQ <= cmdWord[WR_BIT];
      addrQ  <= cmdWord[WR_BIT-1:DATA_W];
      wdataQ <= cmdWord[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 rdataQ <= '0;
    else if (strobe.capture) rdataQ <= linkRdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ   <= 1'b0;
      initQ <= 1'b0;
    end else if (cfgWr) begin
      enQ   <= cfgData[CFG_EN_BIT];
      initQ <= cfgData[CFG_INIT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              errQ <= 1'b0;
    else if (strobe.reject)               errQ <= 1'b1;
    else if (cfgWr && cfgData[CFG_CLR_BIT]) errQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) syncIdleQ <= 1'b0;
    else     syncIdleQ <= linkIdle;
  end

  assign chanEn     = enQ;
  assign cmdIsWrite = writeQ;
  assign linkAddr   = addrQ;
  assign linkWdata  = wdataQ;

  generate
    if (PAD_W > 0) begin : g_pad
      assign statusWord = {{PAD_W{1'b0}}, enQ, errQ, initQ, syncIdleQ,
                           strobe.reqPend, fsmCode, rdataQ};
    end else begin : g_nopad
      assign statusWord = {enQ, errQ, initQ, syncIdleQ,
                           strobe.reqPend, fsmCode, rdataQ};
    end
  endgenerate

endmodule

// File: rtl/rac_channel.sv
module rac_channel
  import rac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmdWr,
  input  logic [ADDR_W+DATA_W:0]     cmdWord,
  input  logic                       vldClrWr,
  input  logic                       vldClrBit,
  input  logic                       cfgWr,
  input  logic [2:0]                 cfgData,
  output logic [DATA_W+15:0]         statusWord,
  output logic                       linkReq,
  output logic                       linkWrite,
  output logic [ADDR_W-1:0]          linkAddr,
  output logic [DATA_W-1:0]          linkWdata,
  input  logic                       linkAck,
  input  logic [DATA_W-1:0]          linkRdata,
  input  logic                       linkIdle
);

  racStrobe_t         strobe;
  logic [STATE_W-1:0] fsmCode;
  logic               chanEn;
  logic               cmdIsWrite;

  rac_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdWr      (cmdWr),
    .vldClrWr   (vldClrWr),
    .vldClrBit  (vldClrBit),
    .chanEn     (chanEn),
    .cmdIsWrite (cmdIsWrite),
    .linkAck    (linkAck),
    .linkIdle   (linkIdle),
    .strobe     (strobe),
    .fsmCode    (fsmCode),
    .linkReq    (linkReq)
  );

  rac_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .cmdWord    (cmdWord),
    .cfgWr      (cfgWr),
    .cfgData    (cfgData),
    .strobe     (strobe),
    .fsmCode    (fsmCode),
    .linkRdata  (linkRdata),
    .linkIdle   (linkIdle),
    .chanEn     (chanEn),
    .cmdIsWrite (cmdIsWrite),
    .linkAddr   (linkAddr),
    .linkWdata  (linkWdata),
    .statusWord (statusWord)
  );

  assign linkWrite = cmdIsWrite;

endmodule

// File: rtl/rac_channel_chk.sv
module rac_channel_chk #(
  parameter int ADDR_W = 15
)(
  input logic              clk,
  input logic              rst,
  input logic              cmdWr,
  input logic              vldClrWr,
  input logic              vldClrBit,
  input logic [23:0]       statusLo,
  input logic              linkReq,
  input logic              linkAck,
  input logic [ADDR_W-1:0] linkAddr
);

  logic [2:0]  fsm;
  logic [15:0] rdField;
  assign fsm     = statusLo[18:16];
  assign rdField = statusLo[15:0];

  AST_ACCEPT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && fsm == 3'd0 && statusLo[23]) |=> (fsm == 3'd2 && linkReq)); // R7

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fsm == 3'd6 && !(vldClrWr && vldClrBit)) |=> (fsm == 3'd6)); // R4

  AST_PARK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (fsm == 3'd6 && vldClrWr && vldClrBit) |=> (fsm == 3'd0)); // R4

  AST_PARK_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (fsm == 3'd6) |=> $stable(rdField)); // R4

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && fsm != 3'd0) |=> statusLo[22]); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (linkReq && !linkAck) |=> (linkReq && $stable(linkAddr))); // R9

  AST_EVEN_CODE: assert property (@(posedge clk) disable iff (rst)
    !statusLo[16]); // R2

endmodule

bind rac_channel rac_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmdWr     (cmdWr),
  .vldClrWr  (vldClrWr),
  .vldClrBit (vldClrBit),
  .statusLo  (statusWord[23:0]),
  .linkReq   (linkReq),
  .linkAck   (linkAck),
  .linkAddr  (linkAddr)
);

// File: tb/sim_rac_channel.sv
`timescale 1ns/1ps
module sim_rac_channel;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmdWr = 1'b0;
  logic [31:0] cmdWord = '0;
  logic        vldClrWr = 1'b0;
  logic        vldClrBit = 1'b0;
  logic        cfgWr = 1'b0;
  logic [2:0]  cfgData = '0;
  logic [31:0] statusWord;
  logic        linkReq;
  logic        linkWrite;
  logic [14:0] linkAddr;
  logic [15:0] linkWdata;
  logic        linkAck = 1'b0;
  logic [15:0] linkRdata = '0;
  logic        linkIdle = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] rdExp = '0;
  bit initExp = 1'b0;

  always #4 clk = ~clk;

  rac_channel u0 (
    .clk(clk), .rst(rst), .cmdWr(cmdWr), .cmdWord(cmdWord),
    .vldClrWr(vldClrWr), .vldClrBit(vldClrBit), .cfgWr(cfgWr), .cfgData(cfgData),
    .statusWord(statusWord), .linkReq(linkReq), .linkWrite(linkWrite),
    .linkAddr(linkAddr), .linkWdata(linkWdata), .linkAck(linkAck),
    .linkRdata(linkRdata), .linkIdle(linkIdle)
  );

  function automatic logic [31:0] mkCmd(bit isWr, logic [15:0] devAddr, logic [15:0] wd);
    return {isWr, devAddr[15:1], wd};
  endfunction

  function automatic logic [2:0] fsmOf(logic [31:0] s);
    return s[18:16];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setCfg(bit en, bit init, bit clr);
    cfgWr = 1'b1; cfgData = {clr, init, en};
    tick();
    cfgWr = 1'b0;
    initExp = init;
  endtask

  task automatic runTxn(bit isWr, logic [15:0] devAddr, logic [15:0] wd,
                        logic [15:0] rd, int ackDly, int idleDly, int inject);
    cmdWord = mkCmd(isWr, devAddr, wd);
    cmdWr = 1'b1;
    tick();
    cmdWr = 1'b0;
    chk("R2 request code", 32'(fsmOf(statusWord)), 32'd2);
    chk("R1 write flag", 32'(linkWrite), 32'(isWr));
    chk("R1 address halved", 32'(linkAddr), 32'(devAddr >> 1));
    chk("R1 write data", 32'(linkWdata), 32'(wd));
    chk("R3 request pending bit", 32'(statusWord[19]), 32'd1);
    for (int i = 0; i < ackDly; i++) begin
      tick();
      chk("R9 request held", {31'd0, linkReq}, 32'd1);
      chk("R9 address held", 32'(linkAddr), 32'(devAddr >> 1));
    end
    linkAck = 1'b1; linkRdata = rd; linkIdle = 1'b0;
    tick();
    linkAck = 1'b0; linkRdata = 16'($urandom);
    chk("R2 line wait code", 32'(fsmOf(statusWord)), 32'd4);
    chk("R3 idle mirror low", 32'(statusWord[20]), 32'd0);
    chk("R3 request pending cleared", 32'(statusWord[19]), 32'd0);
    for (int i = 0; i < idleDly; i++) begin
      tick();
      chk("R2 still waiting line", 32'(fsmOf(statusWord)), 32'd4);
    end
    linkIdle = 1'b1;
    tick();
    chk("R3 idle mirror high", 32'(statusWord[20]), 32'd1);
    if (isWr) begin
      chk("R5 write back to idle", 32'(fsmOf(statusWord)), 32'd0);
      chk("R5 read field untouched", 32'(statusWord[15:0]), 32'(rdExp));
      if (inject == 3) begin
        vldClrWr = 1'b1; vldClrBit = 1'b1;
        tick();
        vldClrWr = 1'b0; vldClrBit = 1'b0;
        chk("R10 stray clear state", 32'(fsmOf(statusWord)), 32'd0);
        chk("R10 stray clear data", 32'(statusWord[15:0]), 32'(rdExp));
        chk("R10 no request", {31'd0, linkReq}, 32'd0);
      end
    end else begin
      rdExp = rd;
      chk("R4 parked code", 32'(fsmOf(statusWord)), 32'd6);
      chk("R4 read data", 32'(statusWord[15:0]), 32'(rd));
      if (inject == 1) begin
        cmdWord = mkCmd(1'b1, 16'h1234, 16'hbeef);
        cmdWr = 1'b1;
        tick();
        cmdWr = 1'b0;
        chk("R6 busy command ignored", 32'(fsmOf(statusWord)), 32'd6);
        chk("R6 no new request", {31'd0, linkReq}, 32'd0);
        chk("R6 sticky error set", 32'(statusWord[22]), 32'd1);
        setCfg(1'b1, initExp, 1'b1);
        chk("R6 error cleared", 32'(statusWord[22]), 32'd0);
        chk("R4 still parked after clear cfg", 32'(fsmOf(statusWord)), 32'd6);
      end
      if (inject == 2) begin
        vldClrWr = 1'b1; vldClrBit = 1'b0;
        tick();
        vldClrWr = 1'b0;
        chk("R4 zero clear no effect", 32'(fsmOf(statusWord)), 32'd6);
      end
      vldClrWr = 1'b1; vldClrBit = 1'b1;
      tick();
      vldClrWr = 1'b0; vldClrBit = 1'b0;
      chk("R4 released to idle", 32'(fsmOf(statusWord)), 32'd0);
      chk("R4 data kept after release", 32'(statusWord[15:0]), 32'(rd));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) tick();
    chk("R8 reset status", statusWord, 32'd0);
    chk("R8 reset request", {31'd0, linkReq}, 32'd0);
    rst = 1'b0;
    tick();
    chk("R3 idle mirror after reset", 32'(statusWord[20]), 32'd1);

    cmdWord = mkCmd(1'b0, 16'h0010, 16'h0);
    cmdWr = 1'b1;
    tick();
    cmdWr = 1'b0;
    chk("R7 disabled stays idle", 32'(fsmOf(statusWord)), 32'd0);
    chk("R7 disabled no request", {31'd0, linkReq}, 32'd0);
    chk("R7 disabled sets error", 32'(statusWord[22]), 32'd1);

    setCfg(1'b1, 1'b0, 1'b1);
    chk("R7 enable bit", 32'(statusWord[23]), 32'd1);
    chk("R7 init flag low", 32'(statusWord[21]), 32'd0);
    chk("R6 error cleared by cfg", 32'(statusWord[22]), 32'd0);
    setCfg(1'b1, 1'b1, 1'b0);
    chk("R3 init flag mirrored", 32'(statusWord[21]), 32'd1);
    chk("R3 upper bits zero", 32'(statusWord[31:24]), 32'h0);

    runTxn(1'b0, 16'hbc0a, 16'h0000, 16'h5aa5, 0, 0, 0);
    runTxn(1'b1, 16'hbc0c, 16'ha55a, 16'h0000, 2, 3, 3);
    runTxn(1'b0, 16'hfffe, 16'h0000, 16'hffff, 3, 1, 1);
    runTxn(1'b0, 16'h0000, 16'h0000, 16'h0001, 1, 2, 2);

    for (int n = 0; n < 60; n++) begin
      bit isWr = 1'($urandom);
      logic [15:0] a = 16'($urandom) & 16'hfffe;
      runTxn(isWr, a, 16'($urandom), 16'($urandom),
             int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule